// File: doc/BRIEF.md
# Rewindable Byte FIFO with Checkpoints

This block is a byte FIFO held in a small RAM. Each side, writer and reader, keeps a live pointer and a checkpoint. A producer pushes the bytes of a packet and then commits them with a write-side mark. If the packet turns out bad, a write-side reload drops the uncommitted bytes. A consumer pops the bytes of a packet and, once the far end has accepted it, commits the read position with a read-side mark. If the packet must be sent again, a read-side reload rewinds to the last commit so that the same bytes come out again.

The reader only sees bytes that the writer has committed. The writer only reuses space that the reader has committed. Because of this, a rewind on either side can never reach data that the other side has already released. Pushes into a full FIFO and pops from an empty one are dropped and raise sticky error flags. The storage sits in a fixed window of a larger RAM, starting at a parameter base address, and both pointers wrap inside that window.

Top module: `rewind_fifo`

## Requirements
- R1: After reset `empty_o`=1, `full_o`=0, `avail_o`=0, `over_o`=0 and `under_o`=0.
- R2: Bytes are read in the order they were pushed. `rdata_o` shows the oldest readable byte combinationally and is valid whenever `empty_o`=0.
- R3: `avail_o` counts the bytes between the read pointer and the last write mark. Pushed bytes become readable only after a later `wr_mark_i`, and `empty_o`=1 exactly when `avail_o`=0.
- R4: `rd_reload_i` returns the read pointer to the last read mark, so popped but uncommitted bytes are read again in the same order.
- R5: `wr_reload_i` returns the write pointer to the last write mark, which discards every byte pushed since that mark.
- R6: `full_o`=1 when DEPTH bytes lie between the write pointer and the read mark. Bytes that have been popped but not read-marked still occupy space.
- R7: A push while `full_o`=1 is ignored and sets `over_o`. A pop while `empty_o`=1 is ignored and sets `under_o`.
- R8: `over_o` and `under_o` stay set until a cycle with `clr_i`=1. If a new error and `clr_i` occur in the same cycle, the flag ends up set.
- R9: On one side, a reload in the same cycle as a mark wins and leaves that side's checkpoint unchanged. A push or pop in the cycle of its own side's reload is ignored and raises no flag.
- R10: Both pointers wrap within the DEPTH-byte window starting at RAM address BASE, and data stays intact across any number of wraps.
- R11: A mark stores the pointer value from before any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write `wdata_i` at the write pointer |
| wdata_i | input | 8 | Byte to push |
| pop_i | input | 1 | Advance the read pointer |
| rdata_o | output | 8 | Oldest readable byte |
| wr_mark_i | input | 1 | Commit the write pointer |
| wr_reload_i | input | 1 | Rewind the write pointer to its commit |
| rd_mark_i | input | 1 | Commit the read pointer |
| rd_reload_i | input | 1 | Rewind the read pointer to its commit |
| clr_i | input | 1 | Clear both error flags |
| empty_o | output | 1 | No committed byte left to read |
| full_o | output | 1 | No space left behind the read commit |
| avail_o | output | FIFO_AW+1 | Readable byte count |
| over_o | output | 1 | Sticky write-overrun flag |
| under_o | output | 1 | Sticky read-underrun flag |

## Verification
A table of single-cycle operations interleaves pushes, pops and marks. It shows whether a mark captures the pointer before or after a same-cycle step, and whether uncommitted writes leak to the reader. Directed sequences then fill the window to DEPTH, drain it, and rewind the reader over the full window. An overrun push would corrupt the first replayed byte, so the replay exposes it. Contested cycles (reload with mark, reload with push or pop, error with clear) separate the priority rules. A long push, commit, pop and commit stream crosses the wrap point several times.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int DATA_W  = 8;
  localparam int SIDE_WR = 0;
  localparam int SIDE_RD = 1;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/rwf_ptr.sv
module rwf_ptr #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          mark_i,
  input  logic          reload_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] ck_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      ck_o  <= '0;
    end else begin
      if (reload_i)    ptr_o <= ck_o;
      else if (step_i) ptr_o <= ptr_o + PW'(1);
      if (mark_i && !reload_i) ck_o <= ptr_o;  // pre-step value
    end
  end

  // R4 / R5
  a_r4_reload_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> ptr_o == $past(ck_o));
  // R11
  a_r11_mark_pre_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i && !reload_i |=> ck_o == $past(ptr_o));
  // R9
  a_r9_reload_beats_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> $stable(ck_o));
endmodule

// File: rtl/rwf_ram.sv
module rwf_ram
  import rwf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  data_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output data_t         rdata_o
);
  localparam int WORDS = 1 << AW;
  data_t mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rwf_flag.sv
module rwf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rwf_pkg::*;
#(
  parameter int FIFO_AW = 4,
  parameter int RAM_AW  = 6,
  parameter int BASE    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [7:0]         wdata_i,
  input  logic               pop_i,
  output logic [7:0]         rdata_o,
  input  logic               wr_mark_i,
  input  logic               wr_reload_i,
  input  logic               rd_mark_i,
  input  logic               rd_reload_i,
  input  logic               clr_i,
  output logic               empty_o,
  output logic               full_o,
  output logic [FIFO_AW:0]   avail_o,
  output logic               over_o,
  output logic               under_o
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int PW    = FIFO_AW + 1;
  localparam logic [RAM_AW-1:0] BASE_A = RAM_AW'(BASE);

  logic          step   [2];
  logic          mark   [2];
  logic          reload [2];
  logic [PW-1:0] ptr    [2];
  logic [PW-1:0] ck     [2];

  logic [PW-1:0] held;
  logic          push_ok, pop_ok;
  logic [RAM_AW-1:0] waddr, raddr;
  data_t         ram_q;

  assign mark[SIDE_WR]   = wr_mark_i;
  assign reload[SIDE_WR] = wr_reload_i;
  assign mark[SIDE_RD]   = rd_mark_i;
  assign reload[SIDE_RD] = rd_reload_i;
  assign step[SIDE_WR]   = push_ok;
  assign step[SIDE_RD]   = pop_ok;

  for (genvar s = 0; s < 2; s++) begin : g_side
    rwf_ptr #(.PW(PW)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step[s]),
      .mark_i   (mark[s]),
      .reload_i (reload[s]),
      .ptr_o    (ptr[s]),
      .ck_o     (ck[s])
    );
  end

  // reader sees committed writes only; writer reuses committed reads only
  assign avail_o = ck[SIDE_WR] - ptr[SIDE_RD];
  assign held    = ptr[SIDE_WR] - ck[SIDE_RD];
  assign empty_o = (avail_o == '0);
  assign full_o  = (held == PW'(DEPTH));
  assign push_ok = push_i && !wr_reload_i && !full_o;
  assign pop_ok  = pop_i  && !rd_reload_i && !empty_o;

  assign waddr = BASE_A + RAM_AW'(ptr[SIDE_WR][FIFO_AW-1:0]);
  assign raddr = BASE_A + RAM_AW'(ptr[SIDE_RD][FIFO_AW-1:0]);

  rwf_ram #(.AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .waddr_i (waddr),
    .wdata_i (data_t'(wdata_i)),
    .raddr_i (raddr),
    .rdata_o (ram_q)
  );
  assign rdata_o = ram_q;

  rwf_flag u_over (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (push_i && !wr_reload_i && full_o),
    .clr_i  (clr_i),
    .flag_o (over_o)
  );

  rwf_flag u_under (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pop_i && !rd_reload_i && empty_o),
    .clr_i  (clr_i),
    .flag_o (under_o)
  );

  a_r7_full_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !wr_reload_i |=> ptr[SIDE_WR] == $past(ptr[SIDE_WR]));
  a_r7_empty_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !rd_reload_i |=> ptr[SIDE_RD] == $past(ptr[SIDE_RD]));
  a_r6_space_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held <= PW'(DEPTH));
  a_r3_avail_within_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o <= held);
  a_r10_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |-> (int'(waddr) >= BASE) && (int'(waddr) < BASE + DEPTH));
endmodule

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NV = 10;
  // {push, wdata[8], pop, wm, rm, rr, exp_avail[5], exp_empty, exp_rdata[8]}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 8'h00},
    {1'b1, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0, 8'h11},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd2, 1'b0, 8'h11},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 1'b0, 8'h22},
    {1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0, 8'h33},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 1'b1, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 1'b0, 8'h33},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd1, 1'b0, 8'h33},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0, wm = 1'b0, wr = 1'b0, rm = 1'b0, rr = 1'b0, clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic empty, full, over, under;
  logic [4:0] avail;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rewind_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .wdata_i(wdata), .pop_i(pop),
    .rdata_o(rdata), .wr_mark_i(wm), .wr_reload_i(wr), .rd_mark_i(rm),
    .rd_reload_i(rr), .clr_i(clr), .empty_o(empty), .full_o(full),
    .avail_o(avail), .over_o(over), .under_o(under)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, hold across one rising edge, release
  task automatic cyc(input bit p, input logic [7:0] d, input bit q, input bit a_wm,
                     input bit a_wr, input bit a_rm, input bit a_rr, input bit c);
    push = p; wdata = d; pop = q; wm = a_wm; wr = a_wr; rm = a_rm; rr = a_rr; clr = c;
    @(negedge clk);
    push = 0; pop = 0; wm = 0; wr = 0; rm = 0; rr = 0; clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 avail", int'(avail), 0);
    chk("R1 over", int'(over), 0);
    chk("R1 under", int'(under), 0);

    // table: R2 R3 R4 R11
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][26], VEC[i][25:18], VEC[i][17], VEC[i][16], 1'b0, VEC[i][15], VEC[i][14], 1'b0);
      chk($sformatf("R3 R11 avail vec%0d", i), int'(avail), int'(VEC[i][13:9]));
      chk($sformatf("R3 empty vec%0d", i), int'(empty), int'(VEC[i][8]));
      if (!VEC[i][8]) chk($sformatf("R2 R4 rdata vec%0d", i), int'(rdata), int'(VEC[i][7:0]));
    end

    // R4: rewind again
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 avail after rewind", int'(avail), 1);
    chk("R4 rdata after rewind", int'(rdata), 'h33);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);

    // R5: discard uncommitted writes
    cyc(1, 8'hA0, 0, 0, 0, 0, 0, 0);
    cyc(1, 8'hA1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R5 avail after wr reload", int'(avail), 0);
    cyc(1, 8'hB0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 avail after commit", int'(avail), 1);
    chk("R5 rdata", int'(rdata), 'hB0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);

    // R6: fill the window
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R6 not full at DEPTH-1", int'(full), 0);
      cyc(1, 8'h40 + 8'(i), 0, 0, 0, 0, 0, 0);
    end
    chk("R6 full at DEPTH", int'(full), 1);
    chk("R3 uncommitted not readable", int'(avail), 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 avail after commit", int'(avail), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 R10 drain data", int'(rdata), 'h40 + i);
      cyc(0, 0, 1, 0, 0, 0, 0, 0);
    end
    chk("R6 still full before read mark", int'(full), 1);

    // R7 R8: overrun
    cyc(1, 8'hEE, 0, 0, 0, 0, 0, 0);
    chk("R7 over set", int'(over), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 over holds", int'(over), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 over cleared", int'(over), 0);
    cyc(1, 8'hEE, 0, 0, 0, 0, 0, 1);
    chk("R8 set beats clear", int'(over), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);

    // R4 R7: replay whole window; overrun byte must not appear
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 avail full replay", int'(avail), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 R7 replay data", int'(rdata), 'h40 + i);
      cyc(0, 0, 1, 0, 0, 0, 0, 0);
    end
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 space freed by read mark", int'(full), 0);
    chk("R3 empty after drain", int'(empty), 1);

    // R7 R8: underrun
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 under set", int'(under), 1);
    chk("R7 avail unchanged", int'(avail), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 under cleared", int'(under), 0);

    // R9: contested cycles
    cyc(0, 0, 1, 0, 0, 0, 1, 0);
    chk("R9 pop during rd reload no flag", int'(under), 0);
    cyc(1, 8'h55, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 push during wr reload ignored", int'(avail), 0);
    cyc(1, 8'h66, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 wr reload beats mark", int'(avail), 0);
    cyc(1, 8'h77, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R9 rd reload with mark avail", int'(avail), 1);
    chk("R9 rd reload with mark data", int'(rdata), 'h77);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 rd mark was not taken", int'(avail), 1);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);

    // R10: long stream across several wraps
    for (int i = 0; i < 40; i++) begin
      cyc(1, 8'(i * 7 + 3), 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0);
      chk("R10 stream data", int'(rdata), (i * 7 + 3) & 'hFF);
      cyc(0, 0, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 0, 0);
    end
    chk("R10 empty after stream", int'(empty), 1);
    chk("R10 no flags after stream", int'(over | under), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule